// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset Action

This block is a down-counting watchdog. It takes the system clock and divides it into a one-microsecond time base. No other count source exists. Software does four things through a small register port:

- loads a reload value;
- sets the run bit;
- writes a restart key at regular intervals to keep the counter away from zero;
- chooses what happens on expiry.

When the count runs out, the block stops. It sets a sticky timeout flag and produces one fixed-length reset pulse on one of three reset outputs:

- a processor-only reset;
- a peripheral reset, gated bit by bit by a two-word mask;
- a whole-system reset.

A fourth setting produces no reset at all.

Expiry can also latch a sticky alternate-boot select. It can also drive a timed pulse on an external pin, whose length is programmed in microseconds. The pin is released-or-pulled-low (open-drain) by default. It can also be driven push-pull, and only in that case can it be active-high.

The register port is a single-cycle write strobe with a combinational read mux, addressed by 3-bit word addresses.

Top module: `wdog_top`

## Requirements
- R1: After reset the reset outputs, `alt_boot_o` and `ext_oe_o` are low. The control register (address 3) reads 0x4, which means run bit clear and reset type "system". The status register (address 4) reads 0, and the count (address 1) holds the reload reset value.
- R2: Writing exactly 0x00004755 to address 2 has three effects. It copies the reload register (address 0) into the count, clears the timeout flag (status bit 0) and restarts the microsecond time base. Any other value written there changes nothing.
- R3: The count decrements once every CLKS_PER_US clocks only while the run bit (control bit 0) is set. With the run bit clear, the count holds.
- R4: After a restart with reload N and the run bit set, expiry occurs at the clock edge max(N,1)×CLKS_PER_US cycles later. The count then stays 0 with status bit 0 set until the next valid restart.
- R5: With type 0 (control bits 2:1), expiry raises `rst_cpu_o` for exactly RST_CYC cycles, starting the cycle after the expiry edge.
- R6: With type 2, expiry raises `rst_sys_o` for exactly RST_CYC cycles with the same timing.
- R7: With type 1, `rst_periph_o` equals the mask for RST_CYC cycles. The low word is at address 5 and the high word at address 6. `rst_cpu_o` and `rst_sys_o` stay low, and at most one reset kind is active at any time.
- R8: With type 3, expiry asserts no reset output, but status bit 0 is still set.
- R9: If control bit 3 is set at expiry, `alt_boot_o` rises and stays high through later restarts (status bit 1 mirrors it). It stays low if bit 3 is clear.
- R10: If control bit 4 is set at expiry, the external pin is asserted for D×CLKS_PER_US cycles starting the cycle after expiry, where D is the zero-extended value at address 7. D = 0, or bit 4 clear, gives no pulse.
- R11: With control bit 5 clear (open-drain), `ext_o` is always 0 and `ext_oe_o` is high only while the pulse is asserted. With bit 5 set (push-pull), `ext_oe_o` is always 1. The asserted level is high only if bit 6 is also set; otherwise it is low, and the idle level is the opposite. Bit 6 has no effect in open-drain mode.
- R12: A valid restart written on the same edge as the final time-base tick wins: no expiry occurs and a fresh full period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| rst_cpu_o | output | 1 | Processor-only reset pulse |
| rst_sys_o | output | 1 | Whole-system reset pulse |
| rst_periph_o | output | 64 | Per-peripheral reset pulses, gated by the mask |
| alt_boot_o | output | 1 | Sticky alternate boot region select |
| ext_o | output | 1 | External pin output value |
| ext_oe_o | output | 1 | External pin output enable |

## Verification
Two events can fall on the same clock edge: the servicing restart and the final decrement that would expire the counter. The bench provokes this by writing the key exactly max(N,1)×CLKS_PER_US cycles after a previous restart. Because a restart also realigns the time base, that edge is known in advance. The bench judges the outcome at the ports. No reset pulse may appear on that edge, and the next expiry must land one full period after the colliding write.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  typedef enum logic [1:0] {
    RT_CPU    = 2'd0,
    RT_SUBSET = 2'd1,
    RT_SYSTEM = 2'd2,
    RT_NONE   = 2'd3
  } rst_kind_e;

  typedef struct packed {
    logic      ext_hi;
    logic      ext_pp;
    logic      ext_en;
    logic      alt_en;
    rst_kind_e kind;
    logic      run;
  } ctrl_t;

  localparam int unsigned CTRL_W     = $bits(ctrl_t);
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned MASK_WORDS = 2;
  localparam int unsigned MASK_W     = MASK_WORDS * 32;

  localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

  localparam logic [ADDR_W-1:0] A_RELOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RESTART = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK0   = 3'd5;
  localparam logic [ADDR_W-1:0] A_PULSE   = 3'd7;

endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned RELOAD_RST = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              tmo_i,
  input  logic              alt_i,
  output logic [CNT_W-1:0]  reload_o,
  output ctrl_t             ctrl_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [31:0]       dur_o,
  output logic              restart_o
);

  localparam ctrl_t CTRL_RST = '{ext_hi: 1'b0, ext_pp: 1'b0, ext_en: 1'b0,
                                 alt_en: 1'b0, kind: RT_SYSTEM, run: 1'b0};

  logic [CNT_W-1:0] reload_q, reload_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic [31:0]      dur_q, dur_d;

  always_comb begin
    reload_d = reload_q;
    ctrl_d   = ctrl_q;
    dur_d    = dur_q;
    if (we_i) begin
      case (addr_i)
        A_RELOAD: reload_d = wdata_i[CNT_W-1:0];
        A_CTRL:   ctrl_d   = ctrl_t'(wdata_i[CTRL_W-1:0]);
        A_PULSE:  dur_d    = wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= CNT_W'(RELOAD_RST);
      ctrl_q   <= CTRL_RST;
      dur_q    <= '0;
    end else begin
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
      dur_q    <= dur_d;
    end
  end

  for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(int'(A_MASK0) + w);
    logic [31:0] word_q, word_d;
    always_comb word_d = (we_i && addr_i == WORD_ADDR) ? wdata_i : word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else         word_q <= word_d;
    end
    assign mask_o[w*32 +: 32] = word_q;
  end

  assign restart_o = we_i && (addr_i == A_RESTART) && (wdata_i == RESTART_KEY);
  assign reload_o  = reload_q;
  assign ctrl_o    = ctrl_q;
  assign dur_o     = dur_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RELOAD: rdata_o[CNT_W-1:0]  = reload_q;
      A_COUNT:  rdata_o[CNT_W-1:0]  = cnt_i;
      A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
      A_STATUS: rdata_o[1:0]        = {alt_i, tmo_i};
      A_PULSE:  rdata_o             = dur_q;
      default: begin
        if (addr_i >= A_MASK0)
          rdata_o = mask_o[32*(int'(addr_i) - int'(A_MASK0)) +: 32];
      end
    endcase
  end

endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
  parameter int unsigned DIV        = 200,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned RELOAD_RST = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tmo_o,
  output logic             fire_o
);

  localparam int unsigned      DIV_W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmo_q, tmo_d;
  logic             tick;
  logic             last;

  always_comb begin
    tick   = (div_q == DIV_LAST);
    last   = (cnt_q <= CNT_W'(1));
    div_d  = (restart_i || tick) ? '0 : div_q + 1'b1;
    fire_o = tick && run_i && !tmo_q && !restart_i && last;
    cnt_d  = cnt_q;
    tmo_d  = tmo_q;
    if (restart_i) begin
      cnt_d = reload_i;
      tmo_d = 1'b0;
    end else if (tick && run_i && !tmo_q) begin
      if (last) begin
        cnt_d = '0;
        tmo_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= CNT_W'(RELOAD_RST);
      tmo_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign cnt_o = cnt_q;
  assign tmo_o = tmo_q;

  // R2: a valid restart loads the reload value and clears the timeout
  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == $past(reload_i)) && !tmo_q);

  // R4: once expired, the counter stays parked at zero until restarted
  a_r4_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && !restart_i) |=> (cnt_q == '0) && tmo_q);

  // R3: with the run bit clear the count does not move
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_rstgen.sv
`timescale 1ns/1ps
module wdog_rstgen
  import wdog_pkg::*;
#(
  parameter int unsigned RST_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  rst_kind_e         kind_i,
  input  logic              alt_en_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              rst_cpu_o,
  output logic              rst_sys_o,
  output logic [MASK_W-1:0] rst_periph_o,
  output logic              alt_boot_o
);

  localparam int unsigned      LEN_W   = $clog2(RST_CYC + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(RST_CYC);

  logic [LEN_W-1:0]  len_q, len_d;
  rst_kind_e         kind_q, kind_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              alt_q, alt_d;
  logic              busy;

  always_comb begin
    len_d  = len_q;
    kind_d = kind_q;
    mask_d = mask_q;
    alt_d  = alt_q || (fire_i && alt_en_i);
    if (fire_i) begin
      len_d  = LEN_MAX;
      kind_d = kind_i;
      mask_d = mask_i;
    end else if (len_q != '0) begin
      len_d = len_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      kind_q <= RT_NONE;
      mask_q <= '0;
      alt_q  <= 1'b0;
    end else begin
      len_q  <= len_d;
      kind_q <= kind_d;
      mask_q <= mask_d;
      alt_q  <= alt_d;
    end
  end

  assign busy         = (len_q != '0);
  assign rst_cpu_o    = busy && (kind_q == RT_CPU);
  assign rst_sys_o    = busy && (kind_q == RT_SYSTEM);
  assign rst_periph_o = (busy && kind_q == RT_SUBSET) ? mask_q : '0;
  assign alt_boot_o   = alt_q;

  // R7: at most one kind of reset is active at a time
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_cpu_o, rst_sys_o, |rst_periph_o}));

  // R8: the no-reset type leaves every reset output quiet
  a_r8_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && kind_i == RT_NONE) |=> !(rst_cpu_o || rst_sys_o || (|rst_periph_o)));

  // R9: alternate boot select is sticky
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_boot_o |=> alt_boot_o);

endmodule

// File: rtl/wdog_extpin.sv
`timescale 1ns/1ps
module wdog_extpin #(
  parameter int unsigned DIV = 200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fire_i,
  input  logic        en_i,
  input  logic        pp_i,
  input  logic        hi_i,
  input  logic [31:0] dur_i,
  output logic        ext_o,
  output logic        ext_oe_o
);

  localparam int unsigned      DIV_W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [31:0]      rem_q, rem_d;
  logic [DIV_W-1:0] sub_q, sub_d;
  logic             active;
  logic             on_level;

  always_comb begin
    rem_d = rem_q;
    sub_d = sub_q;
    if (fire_i && en_i && dur_i != '0) begin
      rem_d = dur_i;
      sub_d = '0;
    end else if (rem_q != '0) begin
      if (sub_q == DIV_LAST) begin
        sub_d = '0;
        rem_d = rem_q - 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      sub_q <= '0;
    end else begin
      rem_q <= rem_d;
      sub_q <= sub_d;
    end
  end

  always_comb begin
    active   = (rem_q != '0);
    on_level = pp_i && hi_i;
    if (pp_i) begin
      ext_oe_o = 1'b1;
      ext_o    = active ? on_level : !on_level;
    end else begin
      ext_oe_o = active;
      ext_o    = 1'b0;
    end
  end

  // R10: a zero duration never starts a pulse
  a_r10_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && dur_i == '0 && rem_q == '0) |=> (rem_q == '0));

  // R10: with the external option off an expiry starts no pulse
  a_r10_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !en_i && rem_q == '0) |=> (rem_q == '0));

endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 200,
  parameter int unsigned RST_CYC     = 16,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned RELOAD_RST  = 1000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        rst_cpu_o,
  output logic        rst_sys_o,
  output logic [63:0] rst_periph_o,
  output logic        alt_boot_o,
  output logic        ext_o,
  output logic        ext_oe_o
);

  logic [1:0]        sync_q;
  logic              rst_n;
  logic [CNT_W-1:0]  cnt, reload;
  logic              tmo, fire, restart;
  ctrl_t             ctrl;
  logic [MASK_W-1:0] mask;
  logic [31:0]       dur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n = sync_q[1];

  wdog_regs #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .cnt_i    (cnt),
    .tmo_i    (tmo),
    .alt_i    (alt_boot_o),
    .reload_o (reload),
    .ctrl_o   (ctrl),
    .mask_o   (mask),
    .dur_o    (dur),
    .restart_o(restart)
  );

  wdog_count #(.DIV(CLKS_PER_US), .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .run_i    (ctrl.run),
    .restart_i(restart),
    .reload_i (reload),
    .cnt_o    (cnt),
    .tmo_o    (tmo),
    .fire_o   (fire)
  );

  wdog_rstgen #(.RST_CYC(RST_CYC)) u_rstgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .fire_i      (fire),
    .kind_i      (ctrl.kind),
    .alt_en_i    (ctrl.alt_en),
    .mask_i      (mask),
    .rst_cpu_o   (rst_cpu_o),
    .rst_sys_o   (rst_sys_o),
    .rst_periph_o(rst_periph_o),
    .alt_boot_o  (alt_boot_o)
  );

  wdog_extpin #(.DIV(CLKS_PER_US)) u_extpin (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .fire_i  (fire),
    .en_i    (ctrl.ext_en),
    .pp_i    (ctrl.ext_pp),
    .hi_i    (ctrl.ext_hi),
    .dur_i   (dur),
    .ext_o   (ext_o),
    .ext_oe_o(ext_oe_o)
  );

endmodule

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;

  localparam int DIV = 4;
  localparam int RC  = 16;
  localparam int RRST = 10;
  localparam logic [2:0] AR_RELOAD = 3'd0, AR_COUNT = 3'd1, AR_RESTART = 3'd2,
                         AR_CTRL = 3'd3, AR_STATUS = 3'd4, AR_MLO = 3'd5,
                         AR_MHI = 3'd6, AR_PULSE = 3'd7;
  localparam logic [31:0] KEY = 32'h4755;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rcpu, rsys, altb, exo, exoe;
  logic [63:0] rper;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int f_cpu, n_cpu, f_sys, n_sys, f_per, n_per, f_as, n_as, n_oe, n_odhi;
  logic [63:0] per_val;
  bit cur_pp, cur_hi;

  always #2.5 clk = ~clk;

  wdog_top #(.CLKS_PER_US(DIV), .RST_CYC(RC), .CNT_W(32), .RELOAD_RST(RRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rst_cpu_o(rcpu), .rst_sys_o(rsys),
    .rst_periph_o(rper), .alt_boot_o(altb), .ext_o(exo), .ext_oe_o(exoe));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic observe(input int ncyc);
    bit as;
    f_cpu = -1; n_cpu = 0; f_sys = -1; n_sys = 0; f_per = -1; n_per = 0;
    f_as = -1; n_as = 0; n_oe = 0; n_odhi = 0; per_val = '0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (rcpu) begin if (f_cpu < 0) f_cpu = k; n_cpu++; end
      if (rsys) begin if (f_sys < 0) f_sys = k; n_sys++; end
      if (|rper) begin if (f_per < 0) f_per = k; n_per++; per_val = rper; end
      as = cur_pp ? (exoe && (cur_hi ? exo : !exo)) : (exoe && !exo);
      if (as) begin if (f_as < 0) f_as = k; n_as++; end
      if (exoe) n_oe++;
      if (!cur_pp && exo) n_odhi++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int t;
    int exp_cnt;
    cur_pp = 0; cur_hi = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state
    chk("R1 rst_cpu", rcpu, 0); chk("R1 rst_sys", rsys, 0); chk("R1 rst_periph", rper, 0);
    chk("R1 alt", altb, 0); chk("R1 oe", exoe, 0);
    rd(AR_CTRL, v);   chk("R1 ctrl", v, 32'h4);
    rd(AR_STATUS, v); chk("R1 status", v, 0);
    rd(AR_COUNT, v);  chk("R1 count", v, RRST);

    // R3: held while not running
    wr(AR_RELOAD, 5); wr(AR_RESTART, KEY);
    repeat (20) @(negedge clk);
    rd(AR_COUNT, v); chk("R3 hold when stopped", v, 5);

    // R3: decrement rate while running
    wr(AR_CTRL, 32'h1); wr(AR_RESTART, KEY);
    repeat (8) @(negedge clk);
    rd(AR_COUNT, v); chk("R3 two ticks", v, 3);

    // R4/R5: expiry timing and CPU pulse
    wr(AR_RESTART, KEY);
    observe(5*DIV + 24);
    chk("R4 expiry cycle", f_cpu, 5*DIV); chk("R5 cpu length", n_cpu, RC);
    rd(AR_COUNT, v); chk("R4 parked at zero", v, 0);
    rd(AR_STATUS, v); chk("R4 timeout flag", v[0], 1);
    repeat (20) @(negedge clk);
    rd(AR_COUNT, v); chk("R4 stays zero", v, 0);

    // R2: wrong key ignored, right key reloads
    wr(AR_RESTART, 32'h4756);
    rd(AR_COUNT, v); chk("R2 bad key count", v, 0);
    rd(AR_STATUS, v); chk("R2 bad key flag", v[0], 1);
    wr(AR_RESTART, 32'h0001_4755);
    rd(AR_STATUS, v); chk("R2 upper bits key flag", v[0], 1);
    wr(AR_RESTART, KEY);
    rd(AR_COUNT, v); chk("R2 reload", v, 5);
    rd(AR_STATUS, v); chk("R2 flag cleared", v[0], 0);

    // R5..R8 sweep over types and reload values
    wr(AR_MLO, 32'h1234_5678); wr(AR_MHI, 32'h9ABC_DEF0);
    for (int kd = 0; kd < 4; kd++) begin
      for (int n = 0; n < 4; n++) begin
        wr(AR_RELOAD, n);
        wr(AR_CTRL, 32'h1 | (kd << 1));
        wr(AR_RESTART, KEY);
        t = ((n == 0) ? 1 : n) * DIV;
        observe(t + RC + 8);
        case (kd)
          0: begin
            chk("R5 cpu start", f_cpu, t); chk("R5 cpu len", n_cpu, RC);
            chk("R5 others quiet", n_sys + n_per, 0);
          end
          1: begin
            chk("R7 periph start", f_per, t); chk("R7 periph len", n_per, RC);
            chk("R7 periph mask", per_val, 64'h9ABC_DEF0_1234_5678);
            chk("R7 others quiet", n_cpu + n_sys, 0);
          end
          2: begin
            chk("R6 sys start", f_sys, t); chk("R6 sys len", n_sys, RC);
            chk("R6 others quiet", n_cpu + n_per, 0);
          end
          default: begin
            chk("R8 no reset", n_cpu + n_sys + n_per, 0);
            rd(AR_STATUS, v); chk("R8 flag still set", v[0], 1);
          end
        endcase
      end
    end
    chk("R9 alt low when disabled", altb, 0);

    // R10/R11 external pin sweep
    wr(AR_RELOAD, 2);
    for (int pp = 0; pp < 2; pp++) begin
      for (int hi = 0; hi < 2; hi++) begin
        for (int di = 0; di < 3; di++) begin
          int d;
          d = (di == 0) ? 0 : ((di == 1) ? 1 : 3);
          wr(AR_PULSE, d);
          wr(AR_CTRL, 32'h1 | (3 << 1) | (1 << 4) | (pp << 5) | (hi << 6));
          cur_pp = pp[0]; cur_hi = (pp == 1) && (hi == 1);
          wr(AR_RESTART, KEY);
          observe(40);
          chk("R10 pulse length", n_as, d*DIV);
          if (d != 0) chk("R10 pulse start", f_as, 2*DIV);
          if (pp == 1) chk("R11 push-pull always driven", n_oe, 40);
          else begin
            chk("R11 open-drain enable window", n_oe, d*DIV);
            chk("R11 open-drain never high", n_odhi, 0);
          end
        end
      end
    end
    wr(AR_PULSE, 3);
    wr(AR_CTRL, 32'h1 | (3 << 1));
    cur_pp = 0; cur_hi = 0;
    wr(AR_RESTART, KEY);
    observe(40);
    chk("R10 ext disabled no pulse", n_as, 0);

    // R9: sticky alternate boot
    wr(AR_RELOAD, 1);
    wr(AR_CTRL, 32'h1 | (3 << 1) | (1 << 3));
    wr(AR_RESTART, KEY);
    observe(DIV + 4);
    chk("R9 alt set", altb, 1);
    wr(AR_RESTART, KEY);
    chk("R9 alt sticky", altb, 1);
    rd(AR_STATUS, v); chk("R9 status bit1", v[1], 1);

    // R12: restart on the expiring edge wins
    wr(AR_RELOAD, 3);
    wr(AR_CTRL, 32'h1);
    wr(AR_RESTART, KEY);
    exp_cnt = 0;
    for (int k = 1; k < 3*DIV; k++) begin
      @(negedge clk);
      if (rcpu) exp_cnt++;
    end
    wr(AR_RESTART, KEY);
    if (rcpu) exp_cnt++;
    chk("R12 no reset on collision", exp_cnt, 0);
    rd(AR_STATUS, v); chk("R12 no timeout flag", v[0], 0);
    observe(3*DIV + RC + 4);
    chk("R12 next expiry full period", f_cpu, 3*DIV);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule